// File: doc/BRIEF.md
# Single-Transfer Address Generator

This block produces the memory address for one-operand signal-processing loads and stores that travel over the main load bus and may target any location in the address space. A request picks one of four pointer registers, held in the general register file as slots 0 to 3, and one of four update modes. The block then issues a 16-bit or 32-bit bus access and returns the updated pointer to the register file.

The four update modes are: leave the pointer alone, add the access size after the access, add an index value after the access, or subtract the access size before the access. The step is 2 for a word and 4 for a longword. No modulo wrap-around region exists on this path. Pointer arithmetic simply rolls over at the address width.

The bus can be held off by a busy input. The request and its address then stay in place, and the pointer write-back is released only in the cycle the bus takes the access, so each completed transfer updates the pointer exactly once. An address that is not aligned to the access size raises a one-cycle error flag instead of a request.

Top module: `stx_agen`

## Requirements
- R1: After reset, `bus_req_o`, `wb_en_o` and `addr_err_o` are low.
- R2: `ptr_sel_i` value k (0..3) takes the pointer from slot k of `ptr_bank_i`, and `wb_sel_o` reports k for that transfer.
- R3: Mode 0 (`mode_i`=00, no update) puts the pointer on the bus and never asserts `wb_en_o`.
- R4: Mode 1 (`mode_i`=01, post-increment) puts the unmodified pointer on the bus and writes back pointer+2 for a word (`size_i`=0) or pointer+4 for a longword (`size_i`=1), rolling over at 2^AW.
- R5: Mode 2 (`mode_i`=10, post-index) puts the unmodified pointer on the bus and writes back pointer+`index_i`, rolling over at 2^AW with no modulo region.
- R6: Mode 3 (`mode_i`=11, pre-decrement) puts pointer-2 (word) or pointer-4 (longword) on the bus and writes back that same value.
- R7: A strobe on `req_i` sampled at one clock edge raises `bus_req_o` with its address in the following cycle, and `bus_size_o` carries 0 for word or 1 for longword.
- R8: While `bus_busy_i` is high, `bus_req_o`, `bus_addr_o` and `bus_size_o` hold and `wb_en_o` stays low. In the first cycle with `bus_busy_i` low, `wb_en_o` pulses once (modes 1-3) and `bus_req_o` drops at the next edge.
- R9: If the bus address would be misaligned (bit 0 set for a word, bits 1:0 nonzero for a longword), `addr_err_o` pulses for one cycle after the strobe and neither `bus_req_o` nor `wb_en_o` is raised.
- R10: A strobe on `req_i` while a request is still pending has no effect: the pending address, size and write-back stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer strobe, one cycle |
| mode_i | input | 2 | Update mode: 00 none, 01 post-inc, 10 post-index, 11 pre-dec |
| size_i | input | 1 | 0 word, 1 longword |
| ptr_sel_i | input | 2 | Pointer slot select |
| ptr_bank_i | input | 4*AW | Current values of the four pointer slots |
| index_i | input | AW | Index register value |
| bus_busy_i | input | 1 | Bus cannot take the access this cycle |
| bus_req_o | output | 1 | Access request to the bus |
| bus_addr_o | output | AW | Access address |
| bus_size_o | output | 1 | Access size, 0 word, 1 longword |
| addr_err_o | output | 1 | Misaligned address pulse |
| wb_en_o | output | 1 | Pointer write-back enable |
| wb_sel_o | output | 2 | Pointer slot to write |
| wb_data_o | output | AW | Updated pointer value |

## Verification
On every cycle the assertions check that a stalled request holds its address and size, that an issued longword address is aligned, that an error pulse never coexists with a request, and that the pending write-back value matches its bus address in pre-decrement mode and exceeds it by the step in post-increment mode. Only the bench scenarios can show the mapping of each select value to its slot, the roll-over of pointer arithmetic at the top of the address space, the single write-back pulse at the release of a stall, and the dropped strobe during a pending transfer, because these depend on the values driven at the ports.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [1:0] {
        UPD_NONE     = 2'b00,
        UPD_POST_INC = 2'b01,
        UPD_POST_IDX = 2'b10,
        UPD_PRE_DEC  = 2'b11
    } upd_mode_e;

    typedef enum logic {
        SZ_WORD = 1'b0,
        SZ_LONG = 1'b1
    } xfer_size_e;

endpackage

// File: rtl/stx_ptr_sel.sv
module stx_ptr_sel #(
    parameter int NPTR = 4,
    parameter int AW   = 32,
    localparam int SW  = $clog2(NPTR)
) (
    input  logic [NPTR-1:0][AW-1:0] bank_i,
    input  logic [SW-1:0]           sel_i,
    output logic [AW-1:0]           ptr_o
);

    logic [NPTR-1:0][AW-1:0] masked;

    // AND-OR multiplexer built slot by slot
    for (genvar g = 0; g < NPTR; g++) begin : g_slot
        assign masked[g] = (sel_i == SW'(g)) ? bank_i[g] : '0;
    end

    always_comb begin
        ptr_o = '0;
        for (int k = 0; k < NPTR; k++) begin
            ptr_o = ptr_o | masked[k];
        end
    end

endmodule

// File: rtl/stx_ea_calc.sv
module stx_ea_calc
    import stx_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] idx_i,
    input  upd_mode_e     mode_i,
    input  xfer_size_e    size_i,
    output logic [AW-1:0] ea_o,
    output logic [AW-1:0] nxt_o,
    output logic          wr_o,
    output logic          misalign_o
);

    localparam logic [AW-1:0] STEP_W = AW'(2);
    localparam logic [AW-1:0] STEP_L = AW'(4);

    logic [AW-1:0] step;

    always_comb begin
        step = (size_i == SZ_LONG) ? STEP_L : STEP_W;
        ea_o  = ptr_i;
        nxt_o = ptr_i;
        wr_o  = 1'b1;
        unique case (mode_i)
            UPD_NONE:     wr_o  = 1'b0;
            UPD_POST_INC: nxt_o = ptr_i + step;
            UPD_POST_IDX: nxt_o = ptr_i + idx_i;
            UPD_PRE_DEC: begin
                ea_o  = ptr_i - step;
                nxt_o = ptr_i - step;
            end
            default: wr_o = 1'b0;
        endcase
        if (size_i == SZ_LONG) misalign_o = (ea_o[1:0] != 2'b00);
        else                   misalign_o = ea_o[0];
    end

endmodule

// File: rtl/stx_issue_ctl.sv
module stx_issue_ctl
    import stx_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_i,
    input  logic          busy_i,
    input  logic [AW-1:0] ea_i,
    input  logic [AW-1:0] nxt_i,
    input  logic          wr_i,
    input  logic          misalign_i,
    input  xfer_size_e    size_i,
    input  upd_mode_e     mode_i,
    input  logic [SW-1:0] sel_i,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    output xfer_size_e    size_o,
    output logic          err_o,
    output logic          wb_en_o,
    output logic [SW-1:0] wb_sel_o,
    output logic [AW-1:0] wb_data_o
);

    typedef struct packed {
        logic          req;
        logic          err;
        logic [AW-1:0] addr;
        xfer_size_e    size;
        upd_mode_e     mode;
        logic          wr;
        logic [SW-1:0] sel;
        logic [AW-1:0] data;
    } issue_t;

    issue_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (st_q.req) begin
            if (!busy_i) st_d.req = 1'b0;
        end else if (strobe_i) begin
            if (misalign_i) begin
                st_d.err = 1'b1;
            end else begin
                st_d.req  = 1'b1;
                st_d.addr = ea_i;
                st_d.size = size_i;
                st_d.mode = mode_i;
                st_d.wr   = wr_i;
                st_d.sel  = sel_i;
                st_d.data = nxt_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o     = st_q.req;
    assign addr_o    = st_q.addr;
    assign size_o    = st_q.size;
    assign err_o     = st_q.err;
    assign wb_en_o   = st_q.req && !busy_i && st_q.wr;
    assign wb_sel_o  = st_q.sel;
    assign wb_data_o = st_q.data;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && busy_i) |=> (st_q.req && $stable(st_q.addr) && $stable(st_q.size)));

    assert_long_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && st_q.size == SZ_LONG) |-> (st_q.addr[1:0] == 2'b00));

    assert_err_noreq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> !st_q.req);

    assert_predec_same_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && st_q.mode == UPD_PRE_DEC) |-> (st_q.data == st_q.addr));

    assert_postinc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && st_q.mode == UPD_POST_INC) |->
        (st_q.data == st_q.addr + ((st_q.size == SZ_LONG) ? AW'(4) : AW'(2))));

endmodule

// File: rtl/stx_agen.sv
module stx_agen
    import stx_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NPTR = 4,
    localparam int SW  = $clog2(NPTR)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_i,
    input  logic [1:0]              mode_i,
    input  logic                    size_i,
    input  logic [SW-1:0]           ptr_sel_i,
    input  logic [NPTR-1:0][AW-1:0] ptr_bank_i,
    input  logic [AW-1:0]           index_i,
    input  logic                    bus_busy_i,
    output logic                    bus_req_o,
    output logic [AW-1:0]           bus_addr_o,
    output logic                    bus_size_o,
    output logic                    addr_err_o,
    output logic                    wb_en_o,
    output logic [SW-1:0]           wb_sel_o,
    output logic [AW-1:0]           wb_data_o
);

    upd_mode_e     mode;
    xfer_size_e    size_in, size_out;
    logic [AW-1:0] ptr, ea, nxt;
    logic          wr, misalign;

    assign mode    = upd_mode_e'(mode_i);
    assign size_in = xfer_size_e'(size_i);

    stx_ptr_sel #(.NPTR(NPTR), .AW(AW)) u_sel (
        .bank_i (ptr_bank_i),
        .sel_i  (ptr_sel_i),
        .ptr_o  (ptr)
    );

    stx_ea_calc #(.AW(AW)) u_ea (
        .ptr_i      (ptr),
        .idx_i      (index_i),
        .mode_i     (mode),
        .size_i     (size_in),
        .ea_o       (ea),
        .nxt_o      (nxt),
        .wr_o       (wr),
        .misalign_o (misalign)
    );

    stx_issue_ctl #(.AW(AW), .SW(SW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_i   (req_i),
        .busy_i     (bus_busy_i),
        .ea_i       (ea),
        .nxt_i      (nxt),
        .wr_i       (wr),
        .misalign_i (misalign),
        .size_i     (size_in),
        .mode_i     (mode),
        .sel_i      (ptr_sel_i),
        .req_o      (bus_req_o),
        .addr_o     (bus_addr_o),
        .size_o     (size_out),
        .err_o      (addr_err_o),
        .wb_en_o    (wb_en_o),
        .wb_sel_o   (wb_sel_o),
        .wb_data_o  (wb_data_o)
    );

    assign bus_size_o = size_out;

    assert_wb_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (bus_req_o && !bus_busy_i));

endmodule

// File: tb/stx_agen_test.sv
module stx_agen_test;

    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_i = 1'b0;
    logic [1:0]      mode_i = 2'b00;
    logic            size_i = 1'b0;
    logic [1:0]      ptr_sel_i = 2'b00;
    logic [3:0][AW-1:0] ptr_bank_i;
    logic [AW-1:0]   index_i = '0;
    logic            bus_busy_i = 1'b0;
    logic            bus_req_o, bus_size_o, addr_err_o, wb_en_o;
    logic [AW-1:0]   bus_addr_o, wb_data_o;
    logic [1:0]      wb_sel_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stx_agen uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i), .size_i(size_i),
        .ptr_sel_i(ptr_sel_i), .ptr_bank_i(ptr_bank_i), .index_i(index_i),
        .bus_busy_i(bus_busy_i), .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o),
        .bus_size_o(bus_size_o), .addr_err_o(addr_err_o), .wb_en_o(wb_en_o),
        .wb_sel_o(wb_sel_o), .wb_data_o(wb_data_o)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive a one-cycle strobe; returns at the negedge after the sampling edge
    task automatic strobe(input logic [1:0] sel, input logic [1:0] md, input logic sz,
                          input logic [AW-1:0] idx);
        @(negedge clk);
        ptr_sel_i = sel; mode_i = md; size_i = sz; index_i = idx; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic xfer(input string tag, input logic [1:0] sel, input logic [1:0] md,
                        input logic sz, input logic [AW-1:0] idx,
                        input logic [AW-1:0] exp_addr, input logic exp_wb,
                        input logic [AW-1:0] exp_data);
        strobe(sel, md, sz, idx);
        chk({tag, " R7 req"}, AW'(bus_req_o), AW'(1));
        chk({tag, " R7 size"}, AW'(bus_size_o), AW'(sz));
        chk({tag, " addr"}, bus_addr_o, exp_addr);
        chk({tag, " R2 wb_sel"}, AW'(wb_sel_o), AW'(sel));
        chk({tag, " wb_en"}, AW'(wb_en_o), AW'(exp_wb));
        if (exp_wb) chk({tag, " wb_data"}, wb_data_o, exp_data);
        @(negedge clk);
        chk({tag, " R8 req drop"}, AW'(bus_req_o), AW'(0));
        chk({tag, " R8 single wb"}, AW'(wb_en_o), AW'(0));
    endtask

    task automatic t_reset();
        chk("R1 bus_req", AW'(bus_req_o), AW'(0));
        chk("R1 wb_en", AW'(wb_en_o), AW'(0));
        chk("R1 addr_err", AW'(addr_err_o), AW'(0));
    endtask

    task automatic t_modes();
        xfer("R3 none", 2'd0, 2'b00, 1'b0, '0, 32'h0000_1000, 1'b0, '0);
        xfer("R4 inc word", 2'd1, 2'b01, 1'b0, '0, 32'h0000_2002, 1'b1, 32'h0000_2004);
        xfer("R4 inc long", 2'd0, 2'b01, 1'b1, '0, 32'h0000_1000, 1'b1, 32'h0000_1004);
        xfer("R4 inc wrap", 2'd2, 2'b01, 1'b1, '0, 32'hFFFF_FFFC, 1'b1, 32'h0000_0000);
        xfer("R5 idx long", 2'd0, 2'b10, 1'b1, 32'h10, 32'h0000_1000, 1'b1, 32'h0000_1010);
        xfer("R5 idx wrap", 2'd2, 2'b10, 1'b0, 32'h8, 32'hFFFF_FFFC, 1'b1, 32'h0000_0004);
        xfer("R6 dec long", 2'd0, 2'b11, 1'b1, '0, 32'h0000_0FFC, 1'b1, 32'h0000_0FFC);
        xfer("R6 dec word", 2'd1, 2'b11, 1'b0, '0, 32'h0000_2000, 1'b1, 32'h0000_2000);
        xfer("R2 slot3", 2'd3, 2'b00, 1'b0, '0, 32'h0000_0100, 1'b0, '0);
    endtask

    task automatic misal(input string tag, input logic [1:0] sel, input logic [1:0] md,
                         input logic sz);
        strobe(sel, md, sz, '0);
        chk({tag, " R9 err"}, AW'(addr_err_o), AW'(1));
        chk({tag, " R9 no req"}, AW'(bus_req_o), AW'(0));
        chk({tag, " R9 no wb"}, AW'(wb_en_o), AW'(0));
        @(negedge clk);
        chk({tag, " R9 err pulse"}, AW'(addr_err_o), AW'(0));
    endtask

    task automatic t_misalign();
        ptr_bank_i[3] = 32'h0000_0101;
        misal("odd word", 2'd3, 2'b01, 1'b0);
        misal("long off2", 2'd1, 2'b00, 1'b1);
        misal("dec word odd", 2'd3, 2'b11, 1'b0);
        misal("dec long off2", 2'd1, 2'b11, 1'b1);
        ptr_bank_i[3] = 32'h0000_0100;
    endtask

    task automatic t_stall();
        bus_busy_i = 1'b1;
        strobe(2'd0, 2'b01, 1'b1, '0);
        for (int i = 0; i < 3; i++) begin
            chk("R8 stall req", AW'(bus_req_o), AW'(1));
            chk("R8 stall addr", bus_addr_o, 32'h0000_1000);
            chk("R8 stall no wb", AW'(wb_en_o), AW'(0));
            @(negedge clk);
        end
        bus_busy_i = 1'b0;
        #1;
        chk("R8 release wb", AW'(wb_en_o), AW'(1));
        chk("R8 release data", wb_data_o, 32'h0000_1004);
        @(negedge clk);
        chk("R8 after req", AW'(bus_req_o), AW'(0));
        chk("R8 after wb", AW'(wb_en_o), AW'(0));
    endtask

    task automatic t_ignore();
        bus_busy_i = 1'b1;
        strobe(2'd0, 2'b10, 1'b1, 32'h20);
        strobe(2'd1, 2'b01, 1'b0, '0);
        chk("R10 addr kept", bus_addr_o, 32'h0000_1000);
        chk("R10 size kept", AW'(bus_size_o), AW'(1));
        chk("R10 sel kept", AW'(wb_sel_o), AW'(0));
        chk("R10 data kept", wb_data_o, 32'h0000_1020);
        bus_busy_i = 1'b0;
        #1;
        chk("R10 wb once", AW'(wb_en_o), AW'(1));
        @(negedge clk);
        @(negedge clk);
        chk("R10 no second req", AW'(bus_req_o), AW'(0));
    endtask

    initial begin
        ptr_bank_i[0] = 32'h0000_1000;
        ptr_bank_i[1] = 32'h0000_2002;
        ptr_bank_i[2] = 32'hFFFF_FFFC;
        ptr_bank_i[3] = 32'h0000_0100;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_misalign();
        t_stall();
        t_ignore();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule